// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two 16-bit count units, each seen through a low-byte and a high-byte register, and one shared configuration byte that sets up both units. A unit counts either ticks of a divide-by-PRESCALE clock divider (12 by default) or falling edges seen on its own count pin. Counting can also be gated by that unit's gate pin. Each unit can work as a 13-bit counter, a 16-bit counter, or an 8-bit counter that reloads itself from the high byte. Unit 0 also has a split mode in which its two bytes count as separate 8-bit counters.

Each unit has a sticky overflow flag. The interrupt logic outside the block clears a flag with an acknowledge pulse, and software clears it by writing a one to that flag's bit. Every overflow of unit 1 is also sent out as a single-cycle tick, which the serial port uses as its bit-rate clock. All registers are reached through a byte-wide port. Writes land on the clock edge and reads are combinational.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00, both overflow flags are 0 and `baud_tick` is 0.
- R2: Configuration byte layout (address 0): bits [3:0] configure unit 0 and bits [7:4] configure unit 1. Within each nibble, bits [1:0] select the mode (00 = 13-bit, 01 = 16-bit, 10 = 8-bit reload, 11 = split), bit 2 selects edge counting (1) or divided clock counting (0), and bit 3 enables gating. In divided clock counting, a running unit advances exactly once in every PRESCALE consecutive clock cycles. The divider runs freely from reset.
- R3: In edge counting, the count pin is sampled on every clock edge, and a count is taken only when one sample is high and the next sample is low. The count becomes visible two clock edges after the pin falls. A rising pin has no effect.
- R4: A unit counts only while its `run_en` bit is 1. If its gate bit is set, it also counts only while its `gate_pin` is 1.
- R5: In 16-bit mode, {high, low} advances by one, and wrapping from 0xFFFF to 0x0000 sets the unit's flag.
- R6: In 13-bit mode, {high[7:0], low[4:0]} advances by one, and low[7:5] keeps its value. Wrapping from all ones sets the flag.
- R7: In reload mode, only the low byte counts. On a wrap from 0xFF, the low byte takes the high byte's value and the flag is set. The high byte does not change.
- R8: With unit 0 in split mode, unit 0's low byte counts under unit 0's own controls and sets flag 0. Unit 0's high byte counts divider ticks while `run_en[1]` is 1 and sets flag 1 on a wrap. Unit 1 holds its value whenever its own mode is split.
- R9: A flag stays set until it is cleared. It is cleared by an `irq_ack` pulse on its bit, or by writing the flag register (address 5) with a 1 in its bit position (bit 0 = unit 0, bit 1 = unit 1). Writing a 0 leaves the flag unchanged. If a set and a clear happen in the same cycle, the set wins.
- R10: Each wrap of unit 1 drives `baud_tick` high for exactly one cycle, on the same edge that sets flag 1 (when unit 0 is not in split mode).
- R11: A write to a unit's low byte (address 1 or 3) or high byte (address 2 or 4) takes priority: that unit does not count in the cycle of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register select (0 config, 1/2 unit 0 low/high, 3/4 unit 1 low/high, 5 flags) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for the selected register |
| run_en | input | 2 | Per-unit run enable |
| cnt_pin | input | 2 | Per-unit external count input |
| gate_pin | input | 2 | Per-unit external gate input |
| irq_ack | input | 2 | Per-unit flag clear pulse |
| ovf_flag | output | 2 | Sticky per-unit overflow flags |
| baud_tick | output | 1 | One-cycle pulse on each unit 1 wrap |

## Verification
Each result has a fixed due time, and every check samples at that time:
- A register write is visible at the next falling clock edge.
- A falling count pin changes the count only after the second rising edge. The bench samples just before that edge and again just after it.
- Flags and `baud_tick` appear on the same edge as the wrap, so the bench compares them at the same sample.

Because the divider runs freely, divided-clock rates are never checked from a fixed start. The bench reads the count at the two ends of a window of exactly PRESCALE×10 cycles and expects a difference of exactly ten.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      TM_13    = 2'b00,
      TM_16    = 2'b01,
      TM_RLD   = 2'b10,
      TM_SPLIT = 2'b11
   } tmr_mode_e;

   // one configuration nibble: gate bit 3, edge select bit 2, mode bits 1:0
   typedef struct packed {
      logic      gate;
      logic      is_cnt;
      tmr_mode_e mode;
   } tmr_cfg_t;

   localparam int unsigned ADDR_W  = 3;
   localparam int unsigned BYTE_W  = 8;
   localparam logic [ADDR_W-1:0] A_CFG  = 3'd0;
   localparam logic [ADDR_W-1:0] A_U0LO = 3'd1;
   localparam logic [ADDR_W-1:0] A_FLAG = 3'd5;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
   parameter int unsigned DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + CW'(1);
   end

   assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin,
   output logic [N-1:0] fall
);
   logic [N-1:0] samp_q, prev_q;

   // reset low so a pin held low through reset never looks like an edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         samp_q <= '0;
         prev_q <= '0;
      end else begin
         samp_q <= pin;
         prev_q <= samp_q;
      end
   end

   assign fall = prev_q & ~samp_q;
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
   import tmr_pkg::*;
#(
   parameter bit HAS_SPLIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tmr_cfg_t          cfg,
   input  logic              cnt_en,
   input  logic              aux_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] lo,
   output logic [BYTE_W-1:0] hi,
   output logic              ovf_main,
   output logic              ovf_aux
);
   localparam int unsigned W13 = BYTE_W + 5;
   localparam int unsigned W16 = 2 * BYTE_W;

   logic [BYTE_W-1:0] lo_q, hi_q, lo_d, hi_d;
   logic [BYTE_W-1:0] sp_lo, sp_hi;
   logic              sp_ovm, sp_ova;
   logic [W13-1:0]    v13;
   logic [W16-1:0]    v16;
   logic              busy;

   assign v13  = {hi_q, lo_q[4:0]};
   assign v16  = {hi_q, lo_q};
   assign busy = wr_lo | wr_hi;

   generate
      if (HAS_SPLIT) begin : g_split
         assign sp_lo  = cnt_en ? lo_q + 8'd1 : lo_q;
         assign sp_ovm = cnt_en & (&lo_q);
         assign sp_hi  = aux_en ? hi_q + 8'd1 : hi_q;
         assign sp_ova = aux_en & (&hi_q);
      end else begin : g_hold
         // no split variant: the unit freezes, the aux tick has no effect
         assign sp_lo  = lo_q;
         assign sp_hi  = hi_q;
         assign sp_ovm = 1'b0;
         assign sp_ova = aux_en & 1'b0;
      end
   endgenerate

   always_comb begin
      lo_d     = lo_q;
      hi_d     = hi_q;
      ovf_main = 1'b0;
      ovf_aux  = 1'b0;
      if (!busy) begin
         case (cfg.mode)
            TM_13: if (cnt_en) begin
               {hi_d, lo_d[4:0]} = v13 + W13'(1);
               ovf_main          = &v13;
            end
            TM_16: if (cnt_en) begin
               {hi_d, lo_d} = v16 + W16'(1);
               ovf_main     = &v16;
            end
            TM_RLD: if (cnt_en) begin
               ovf_main = &lo_q;
               lo_d     = (&lo_q) ? hi_q : lo_q + 8'd1;
            end
            default: begin
               lo_d     = sp_lo;
               hi_d     = sp_hi;
               ovf_main = sp_ovm;
               ovf_aux  = sp_ova;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else begin
         lo_q <= wr_lo ? wdata : lo_d;
         hi_q <= wr_hi ? wdata : hi_d;
      end
   end

   assign lo = lo_q;
   assign hi = hi_q;
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
   import tmr_pkg::*;
#(
   parameter int unsigned PRESCALE = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic [1:0]        run_en,
   input  logic [1:0]        cnt_pin,
   input  logic [1:0]        gate_pin,
   input  logic [1:0]        irq_ack,
   output logic [1:0]        ovf_flag,
   output logic              baud_tick
);
   localparam int unsigned NU = 2;

   generate
      if (PRESCALE < 2) begin : g_bad_div
         $error("tmr_pair: PRESCALE must be at least 2");
      end
   endgenerate

   logic [BYTE_W-1:0] mode_q;
   logic [1:0]        flag_q, set_f, clr_f;
   logic              baud_q;
   logic              pre_tick;
   logic [NU-1:0]     fall;
   logic [BYTE_W-1:0] lo_v [NU];
   logic [BYTE_W-1:0] hi_v [NU];
   logic [NU-1:0]     ovf_m, ovf_a;
   logic              split0;

   tmr_prescale #(.DIV(PRESCALE)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(pre_tick)
   );

   tmr_edge #(.N(NU)) u_edge (
      .clk(clk), .rst_n(rst_n), .pin(cnt_pin), .fall(fall)
   );

   generate
      for (genvar g = 0; g < NU; g++) begin : g_unit
         localparam logic [ADDR_W-1:0] A_LO = A_U0LO + ADDR_W'(2 * g);
         localparam logic [ADDR_W-1:0] A_HI = A_LO + ADDR_W'(1);
         tmr_cfg_t cfg;
         logic     en, aux;
         assign cfg = tmr_cfg_t'(mode_q[4*g +: 4]);
         assign en  = run_en[g] & (~cfg.gate | gate_pin[g]) &
                      (cfg.is_cnt ? fall[g] : pre_tick);
         assign aux = (g == 0) ? (run_en[1] & pre_tick) : 1'b0;
         tmr_unit #(.HAS_SPLIT(g == 0)) u_unit (
            .clk(clk), .rst_n(rst_n), .cfg(cfg),
            .cnt_en(en), .aux_en(aux),
            .wr_lo(reg_wr && reg_addr == A_LO),
            .wr_hi(reg_wr && reg_addr == A_HI),
            .wdata(reg_wdata),
            .lo(lo_v[g]), .hi(hi_v[g]),
            .ovf_main(ovf_m[g]), .ovf_aux(ovf_a[g])
         );
      end
   endgenerate

   assign split0   = (mode_q[1:0] == 2'b11);
   assign set_f[0] = ovf_m[0];
   assign set_f[1] = split0 ? ovf_a[0] : (ovf_m[1] | ovf_a[1]);
   assign clr_f    = irq_ack | ({2{reg_wr && reg_addr == A_FLAG}} & reg_wdata[1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= '0;
         flag_q <= '0;
         baud_q <= 1'b0;
      end else begin
         if (reg_wr && reg_addr == A_CFG) mode_q <= reg_wdata;
         flag_q <= set_f | (flag_q & ~clr_f);
         baud_q <= ovf_m[1];
      end
   end

   always_comb begin
      case (reg_addr)
         3'd0:    reg_rdata = mode_q;
         3'd1:    reg_rdata = lo_v[0];
         3'd2:    reg_rdata = hi_v[0];
         3'd3:    reg_rdata = lo_v[1];
         3'd4:    reg_rdata = hi_v[1];
         3'd5:    reg_rdata = {6'd0, flag_q};
         default: reg_rdata = '0;
      endcase
   end

   assign ovf_flag  = flag_q;
   assign baud_tick = baud_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] reg_addr,
   input logic       reg_wr,
   input logic [7:0] reg_wdata,
   input logic [1:0] irq_ack,
   input logic [1:0] ovf_flag,
   input logic       baud_tick,
   input logic [7:0] mode_q,
   input logic [7:0] t0_lo,
   input logic [7:0] t1_lo,
   input logic [7:0] t1_hi
);
   AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ovf_flag == 2'b00 && !baud_tick)); // R1

   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd1) |=> (t0_lo == $past(reg_wdata))); // R11

   AST_SPLIT_U1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[5:4] == 2'b11 && !reg_wr) |=> ($stable(t1_lo) && $stable(t1_hi))); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag[0] && !irq_ack[0] && !(reg_wr && reg_addr == 3'd5 && reg_wdata[0]))
      |=> ovf_flag[0]); // R9

   AST_BAUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      baud_tick |=> !baud_tick); // R10

   AST_BAUD_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_tick && mode_q[1:0] != 2'b11) |-> ovf_flag[1]); // R10
endmodule

bind tmr_pair tmr_pair_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .irq_ack(irq_ack), .ovf_flag(ovf_flag),
   .baud_tick(baud_tick), .mode_q(mode_q), .t0_lo(lo_v[0]),
   .t1_lo(lo_v[1]), .t1_hi(hi_v[1])
);

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PRE = 12;

   typedef struct packed {
      logic       unit;
      logic [7:0] mode;
      logic [7:0] lo;
      logic [7:0] hi;
      logic [3:0] pulses;
      logic [7:0] exp_lo;
      logic [7:0] exp_hi;
      logic       exp_flag;
   } vec_t;

   // edge-counting vectors: 16-bit (R5), 13-bit (R6), reload (R7)
   localparam vec_t VECS [8] = '{
      '{1'b0, 8'h05, 8'hFE, 8'h00, 4'd3, 8'h01, 8'h01, 1'b0},
      '{1'b0, 8'h05, 8'hFF, 8'hFF, 4'd1, 8'h00, 8'h00, 1'b1},
      '{1'b0, 8'h04, 8'hFF, 8'h12, 4'd1, 8'hE0, 8'h13, 1'b0},
      '{1'b0, 8'h04, 8'h3F, 8'hFF, 4'd1, 8'h20, 8'h00, 1'b1},
      '{1'b0, 8'h06, 8'hFD, 8'h80, 4'd4, 8'h81, 8'h80, 1'b1},
      '{1'b0, 8'h06, 8'h10, 8'h55, 4'd2, 8'h12, 8'h55, 1'b0},
      '{1'b1, 8'h50, 8'hFF, 8'hFF, 4'd1, 8'h00, 8'h00, 1'b1},
      '{1'b1, 8'h60, 8'hFE, 8'h07, 4'd3, 8'h08, 8'h07, 1'b1}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [1:0] run_en = '0;
   logic [1:0] cnt_pin = 2'b11;
   logic [1:0] gate_pin = '0;
   logic [1:0] irq_ack = '0;
   logic [1:0] ovf_flag;
   logic       baud_tick;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   tmr_pair #(.PRESCALE(PRE)) u_tmr_pair (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run_en(run_en),
      .cnt_pin(cnt_pin), .gate_pin(gate_pin), .irq_ack(irq_ack),
      .ovf_flag(ovf_flag), .baud_tick(baud_tick)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic pulse(input int ch);
      @(negedge clk);
      cnt_pin[ch] = 1'b0;
      repeat (3) @(negedge clk);
      cnt_pin[ch] = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   function automatic string req_of(input logic [1:0] m);
      case (m)
         2'b00:   return "R6";
         2'b01:   return "R5";
         default: return "R7";
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD * 60000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, a, b;
      int nb;
      logic pf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i < 6; i++) begin
         rd(3'(i), v);
         chk("R1", {8'd0, v}, 16'h0000);
      end
      chk("R1", {14'd0, ovf_flag}, 16'h0);
      chk("R1", {15'd0, baud_tick}, 16'h0);

      // table walk: edge counting in each mode
      for (int k = 0; k < 8; k++) begin
         vec_t e;
         e = VECS[k];
         run_en = 2'b00;
         wr(3'd0, e.mode);
         wr(e.unit ? 3'd3 : 3'd1, e.lo);
         wr(e.unit ? 3'd4 : 3'd2, e.hi);
         wr(3'd5, 8'h03);
         run_en[e.unit] = 1'b1;
         for (int p = 0; p < int'(e.pulses); p++) pulse(int'(e.unit));
         rd(e.unit ? 3'd3 : 3'd1, v);
         chk(req_of(e.mode[e.unit ? 5 : 1 -: 2]), {8'd0, v}, {8'd0, e.exp_lo});
         rd(e.unit ? 3'd4 : 3'd2, v);
         chk(req_of(e.mode[e.unit ? 5 : 1 -: 2]), {8'd0, v}, {8'd0, e.exp_hi});
         chk(req_of(e.mode[e.unit ? 5 : 1 -: 2]), {15'd0, ovf_flag[e.unit]}, {15'd0, e.exp_flag});
         run_en = 2'b00;
      end

      // R2 divided clock rate over a 10*PRE window
      wr(3'd0, 8'h01);
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00);
      run_en = 2'b01;
      repeat (5) @(negedge clk);
      rd(3'd1, a);
      repeat (10 * PRE - 1) @(negedge clk);
      rd(3'd1, b);
      chk("R2", {8'd0, b - a}, 16'd10);
      // R4 run enable low stops counting
      run_en = 2'b00;
      rd(3'd1, a);
      repeat (3 * PRE) @(negedge clk);
      rd(3'd1, b);
      chk("R4", {8'd0, b}, {8'd0, a});

      // R3 edge timing and rising-edge immunity
      wr(3'd0, 8'h05);
      wr(3'd1, 8'h10);
      wr(3'd2, 8'h00);
      run_en = 2'b01;
      reg_addr = 3'd1;
      @(negedge clk);
      cnt_pin[0] = 1'b0;
      @(negedge clk);
      #1 chk("R3", {8'd0, reg_rdata}, 16'h0010);
      @(negedge clk);
      #1 chk("R3", {8'd0, reg_rdata}, 16'h0011);
      cnt_pin[0] = 1'b1;
      repeat (4) @(negedge clk);
      #1 chk("R3", {8'd0, reg_rdata}, 16'h0011);

      // R11 write on the counting edge wins, the edge is lost
      wr(3'd1, 8'h20);
      @(negedge clk);
      cnt_pin[0] = 1'b0;
      @(negedge clk);
      reg_addr = 3'd1; reg_wdata = 8'h40; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      #1 chk("R11", {8'd0, reg_rdata}, 16'h0040);
      repeat (4) @(negedge clk);
      #1 chk("R11", {8'd0, reg_rdata}, 16'h0040);
      cnt_pin[0] = 1'b1;
      repeat (3) @(negedge clk);

      // R4 gate qualification
      wr(3'd0, 8'h0D);
      wr(3'd1, 8'h00);
      gate_pin[0] = 1'b0;
      pulse(0); pulse(0);
      rd(3'd1, v);
      chk("R4", {8'd0, v}, 16'h0000);
      gate_pin[0] = 1'b1;
      pulse(0); pulse(0);
      rd(3'd1, v);
      chk("R4", {8'd0, v}, 16'h0002);
      run_en = 2'b00;
      pulse(0);
      rd(3'd1, v);
      chk("R4", {8'd0, v}, 16'h0002);
      gate_pin[0] = 1'b0;

      // R10 baud tick from unit 1 wrap
      wr(3'd0, 8'h50);
      wr(3'd3, 8'hFF);
      wr(3'd4, 8'hFF);
      wr(3'd5, 8'h03);
      run_en = 2'b10;
      @(negedge clk);
      cnt_pin[1] = 1'b0;
      nb = 0;
      pf = ovf_flag[1];
      for (int i = 0; i < 6; i++) begin
         @(negedge clk);
         if (baud_tick) begin
            nb++;
            chk("R10", {14'd0, pf, ovf_flag[1]}, 16'b01);
         end
         pf = ovf_flag[1];
      end
      chk("R10", 16'(nb), 16'd1);
      cnt_pin[1] = 1'b1;
      run_en = 2'b00;
      repeat (3) @(negedge clk);

      // R9 writing a 0 keeps the flag, ack clears it
      wr(3'd5, 8'h01);
      chk("R9", {15'd0, ovf_flag[1]}, 16'h1);
      @(negedge clk);
      irq_ack = 2'b10;
      @(negedge clk);
      irq_ack = 2'b00;
      #1 chk("R9", {15'd0, ovf_flag[1]}, 16'h0);

      // R8 split mode
      wr(3'd0, 8'h37);
      wr(3'd1, 8'hFF);
      wr(3'd2, 8'hFE);
      wr(3'd3, 8'h33);
      wr(3'd4, 8'h44);
      wr(3'd5, 8'h03);
      run_en = 2'b11;
      repeat (40) @(negedge clk);
      chk("R8", {14'd0, ovf_flag}, 16'b10);
      rd(3'd3, v);
      chk("R8", {8'd0, v}, 16'h0033);
      pulse(0);
      rd(3'd1, v);
      chk("R8", {8'd0, v}, 16'h0000);
      chk("R8", {15'd0, ovf_flag[0]}, 16'h1);
      rd(3'd2, a);
      repeat (10 * PRE - 1) @(negedge clk);
      rd(3'd2, b);
      chk("R8", {8'd0, b - a}, 16'd10);
      // R9 write-one clear
      wr(3'd5, 8'h01);
      chk("R9", {15'd0, ovf_flag[0]}, 16'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule